// File: doc/BRIEF.md
# LCD Dot-Clock Timing Generator

This block drives the sync and enable timing of a parallel RGB panel. Software fills in a small bank of write-only registers:
- a horizontal and a vertical frame length;
- the two sync pulse widths;
- the wait counts, measured from the leading edge of each sync pulse, that mark where active video starts;
- the active pixel and line counts;
- a control word with the run bit, the enables and the polarity selects;
- the address of the next frame buffer.

Once the run bit is set, a pixel counter and a line counter step through the frame. Registered outputs are derived from the counter state: hsync, vsync, data-enable, a pixel-request strobe, and line-start and frame-start pulses.

All timing fields are double-buffered. A timing write lands in a shadow copy, and the counters only pick it up at a frame boundary. The frame base address works the same way: the pending address is moved into the current address at the first clock of each vertical sync pulse, so a panning update never tears a frame. The 3-bit output-delay code and the falling-edge launch select are passed straight through for the external pad logic.

Top module: `lcd_timing_gen`

## Requirements
- R1: During and after reset, and with all registers cleared, hsync, vsync and data-enable sit at their inactive level (high, since every polarity bit is 0). pix_req, line_start and frame_start are 0, cur_base is 0 and dly_code is 0.
- R2: While run (control bit 0) is set, each line lasts the horizontal total (register 1, bits 17:0) in clocks, and each frame lasts the vertical total (register 2) in lines. The first clock after run rises is pixel 0 of line 0.
- R3: hsync is active for the first hsync-width clocks of every line. Active-high is selected by control bit 4, otherwise the pulse is active-low.
- R4: vsync is active during the first vsync-width lines of every frame (register 4, counted in whole lines). Active-high is selected by control bit 3.
- R5: Data-enable is active on pixels hwait through hwait+hcount-1 of lines vwait through vwait+vcount-1. The waits come from register 3: hwait is bits 27:16, vwait is bits 15:0. The counts come from register 5: vcount is bits 31:16, hcount is bits 15:0. Control bit 5 selects active-high. With control bit 2 clear, data-enable stays at its inactive level.
- R6: pix_req is an active-high strobe asserted one clock before each data-enable pixel.
- R7: line_start pulses for one clock at pixel 0 of every line. frame_start pulses together with it on line 0.
- R8: A write to register 6 changes cur_base only in the clock where frame_start is high, and cur_base then takes the last address written.
- R9: With control bit 1 clear, hsync and vsync stay at their inactive level while the counters keep running. With run clear, the counters hold at pixel 0 of line 0 and no pulse is produced.
- R10: Timing registers written while running take effect at the next frame start, and not within the current frame.
- R11: dly_code follows control bits 10:8 and clk_fall follows control bit 6 in the clock after the write.
- R12: The hsync width field sits at bits 31:18 (14 bits) when HS_WIDE is 1, or at bits 31:24 (8 bits) when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data-enable |
| pix_req | output | 1 | Pixel request, one clock ahead of data-enable |
| line_start | output | 1 | First clock of a line |
| frame_start | output | 1 | First clock of a frame |
| clk_fall | output | 1 | Launch data on the falling clock edge |
| dly_code | output | DLY_W | Output-delay code, 2 ns steps |
| cur_base | output | AW | Frame base in use |

## Verification
The assertions take for granted that the programmed timing is consistent in every partial combination the registers can pass through:
- the horizontal total is at least 2;
- hsync width, hwait and hwait+hcount all fit inside the line;
- hwait is at least 1;
- vwait+vcount fits inside the frame.

The stimulus orders its mid-run updates so that every intermediate mix of old and new values still meets these limits. The bench programs one small frame, then reprograms the timing while running and checks that the change waits for the frame boundary. It also flips polarities, drops each enable in turn, and stops and restarts the run bit, comparing every output against a behavioural model on every clock.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

   typedef enum logic [2:0] {
      RG_CTRL   = 3'd0,
      RG_HTIME  = 3'd1,
      RG_VTOTAL = 3'd2,
      RG_WAIT   = 3'd3,
      RG_VSW    = 3'd4,
      RG_ACTIVE = 3'd5,
      RG_NEXT   = 3'd6
   } tg_reg_e;

   localparam int CB_RUN  = 0;
   localparam int CB_SYNC = 1;
   localparam int CB_DEN  = 2;
   localparam int CB_VSHI = 3;
   localparam int CB_HSHI = 4;
   localparam int CB_DEHI = 5;
   localparam int CB_FALL = 6;
   localparam int CB_DLY  = 8;

   typedef struct packed {
      logic run;
      logic sync_en;
      logic de_en;
      logic vs_hi;
      logic hs_hi;
      logic de_hi;
      logic fall;
   } tg_ctrl_t;

endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
   import lcd_tg_pkg::*;
#(
   parameter int HW      = 18,
   parameter int VW      = 16,
   parameter int WW      = 12,
   parameter int VSW_W   = 18,
   parameter int HSW_W   = 14,
   parameter int HSW_LSB = 18,
   parameter int AW      = 32,
   parameter int DLY_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              frame_end,
   input  logic              frame_go,
   output tg_ctrl_t          ctrl_q,
   output logic [DLY_W-1:0]  dly_q,
   output logic [HW-1:0]     a_htot,
   output logic [HSW_W-1:0]  a_hsw,
   output logic [WW-1:0]     a_hwait,
   output logic [HW-1:0]     a_hval,
   output logic [VW-1:0]     a_vtot,
   output logic [VSW_W-1:0]  a_vsw,
   output logic [VW-1:0]     a_vwait,
   output logic [VW-1:0]     a_vval,
   output logic [AW-1:0]     cur_base
);

   logic [HW-1:0]    s_htot;
   logic [HSW_W-1:0] s_hsw;
   logic [WW-1:0]    s_hwait;
   logic [HW-1:0]    s_hval;
   logic [VW-1:0]    s_vtot;
   logic [VSW_W-1:0] s_vsw;
   logic [VW-1:0]    s_vwait;
   logic [VW-1:0]    s_vval;
   logic [AW-1:0]    next_base;

   // shadow bank, written by software at any time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         dly_q     <= '0;
         s_htot    <= '0;
         s_hsw     <= '0;
         s_hwait   <= '0;
         s_hval    <= '0;
         s_vtot    <= '0;
         s_vsw     <= '0;
         s_vwait   <= '0;
         s_vval    <= '0;
         next_base <= '0;
      end else if (wr_en) begin
         case (tg_reg_e'(wr_addr))
            RG_CTRL: begin
               ctrl_q.run     <= wr_data[CB_RUN];
               ctrl_q.sync_en <= wr_data[CB_SYNC];
               ctrl_q.de_en   <= wr_data[CB_DEN];
               ctrl_q.vs_hi   <= wr_data[CB_VSHI];
               ctrl_q.hs_hi   <= wr_data[CB_HSHI];
               ctrl_q.de_hi   <= wr_data[CB_DEHI];
               ctrl_q.fall    <= wr_data[CB_FALL];
               dly_q          <= wr_data[CB_DLY +: DLY_W];
            end
            RG_HTIME: begin
               s_htot <= wr_data[HW-1:0];
               s_hsw  <= wr_data[HSW_LSB +: HSW_W];
            end
            RG_VTOTAL: s_vtot <= wr_data[VW-1:0];
            RG_WAIT: begin
               s_hwait <= wr_data[16 +: WW];
               s_vwait <= wr_data[VW-1:0];
            end
            RG_VSW:  s_vsw <= wr_data[VSW_W-1:0];
            RG_ACTIVE: begin
               s_hval <= HW'(wr_data[15:0]);
               s_vval <= wr_data[16 +: VW];
            end
            RG_NEXT: next_base <= wr_data[AW-1:0];
            default: ;
         endcase
      end
   end

   // working bank: follows the shadow while idle, else only at frame end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_htot  <= '0;
         a_hsw   <= '0;
         a_hwait <= '0;
         a_hval  <= '0;
         a_vtot  <= '0;
         a_vsw   <= '0;
         a_vwait <= '0;
         a_vval  <= '0;
      end else if (!ctrl_q.run || frame_end) begin
         a_htot  <= s_htot;
         a_hsw   <= s_hsw;
         a_hwait <= s_hwait;
         a_hval  <= s_hval;
         a_vtot  <= s_vtot;
         a_vsw   <= s_vsw;
         a_vwait <= s_vwait;
         a_vval  <= s_vval;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cur_base <= '0;
      else if (frame_go) cur_base <= next_base;
   end

endmodule

// File: rtl/lcd_tg_counter.sv
module lcd_tg_counter #(
   parameter int HW = 18,
   parameter int VW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [HW-1:0] htot,
   input  logic [VW-1:0] vtot,
   output logic [HW-1:0] hcnt,
   output logic [VW-1:0] vcnt,
   output logic          frame_end,
   output logic          frame_go
);

   logic h_last, v_last;

   assign h_last    = (hcnt == htot - 1'b1);
   assign v_last    = (vcnt == vtot - 1'b1);
   assign frame_end = run && h_last && v_last;
   assign frame_go  = run && (hcnt == '0) && (vcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (!run) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (h_last) begin
         hcnt <= '0;
         vcnt <= v_last ? '0 : vcnt + 1'b1;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

endmodule

// File: rtl/lcd_tg_outgen.sv
module lcd_tg_outgen
   import lcd_tg_pkg::*;
#(
   parameter int HW    = 18,
   parameter int VW    = 16,
   parameter int WW    = 12,
   parameter int VSW_W = 18,
   parameter int HSW_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tg_ctrl_t         ctrl,
   input  logic [HW-1:0]    hcnt,
   input  logic [VW-1:0]    vcnt,
   input  logic [HSW_W-1:0] hsw,
   input  logic [WW-1:0]    hwait,
   input  logic [HW-1:0]    hval,
   input  logic [VSW_W-1:0] vsw,
   input  logic [VW-1:0]    vwait,
   input  logic [VW-1:0]    vval,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic             pix_req,
   output logic             line_start,
   output logic             frame_start,
   output logic             de_win
);

   localparam int HX = HW + 2;
   localparam int VX = ((VSW_W > VW) ? VSW_W : VW) + 2;

   logic [HX-1:0] h_x, h_nx, h_lo, h_hi;
   logic [VX-1:0] v_x, v_lo, v_hi;
   logic          hs_on, vs_on, v_in, de_on, pr_on;

   assign h_x   = HX'(hcnt);
   assign h_nx  = h_x + 1'b1;
   assign h_lo  = HX'(hwait);
   assign h_hi  = HX'(hwait) + HX'(hval);
   assign v_x   = VX'(vcnt);
   assign v_lo  = VX'(vwait);
   assign v_hi  = VX'(vwait) + VX'(vval);

   assign hs_on = ctrl.run && (h_x < HX'(hsw));
   assign vs_on = ctrl.run && (v_x < VX'(vsw));
   assign v_in  = (v_x >= v_lo) && (v_x < v_hi);
   assign de_on = ctrl.run && v_in && (h_x >= h_lo) && (h_x < h_hi);
   assign pr_on = ctrl.run && v_in && (h_nx >= h_lo) && (h_nx < h_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync       <= 1'b1;
         vsync       <= 1'b1;
         de          <= 1'b1;
         pix_req     <= 1'b0;
         line_start  <= 1'b0;
         frame_start <= 1'b0;
         de_win      <= 1'b0;
      end else begin
         hsync       <= (ctrl.sync_en && hs_on) ? ctrl.hs_hi : !ctrl.hs_hi;
         vsync       <= (ctrl.sync_en && vs_on) ? ctrl.vs_hi : !ctrl.vs_hi;
         de          <= (ctrl.de_en && de_on) ? ctrl.de_hi : !ctrl.de_hi;
         pix_req     <= pr_on;
         line_start  <= ctrl.run && (hcnt == '0);
         frame_start <= ctrl.run && (hcnt == '0) && (vcnt == '0);
         de_win      <= de_on;
      end
   end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcd_tg_pkg::*;
#(
   parameter int HW      = 18,
   parameter int VW      = 16,
   parameter int WW      = 12,
   parameter int VSW_W   = 18,
   parameter bit HS_WIDE = 1'b1,
   parameter int AW      = 32,
   parameter int DLY_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [31:0]      wr_data,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic             pix_req,
   output logic             line_start,
   output logic             frame_start,
   output logic             clk_fall,
   output logic [DLY_W-1:0] dly_code,
   output logic [AW-1:0]    cur_base
);

   localparam int HSW_W   = HS_WIDE ? 14 : 8;
   localparam int HSW_LSB = HS_WIDE ? 18 : 24;

   generate
      if (HW < 16 || HW > HSW_LSB) begin : g_bad_hw
         $error("HW must lie between 16 and the hsync width offset");
      end
      if (VW > 16 || WW > 16 || VSW_W > 32) begin : g_bad_vw
         $error("vertical or wait field too wide for its register");
      end
      if (AW > 32 || DLY_W < 1 || CB_DLY + DLY_W > 32) begin : g_bad_aw
         $error("address or delay field does not fit 32 bits");
      end
   endgenerate

   tg_ctrl_t         ctrl_q;
   logic [HW-1:0]    a_htot, a_hval, hcnt;
   logic [HSW_W-1:0] a_hsw;
   logic [WW-1:0]    a_hwait;
   logic [VW-1:0]    a_vtot, a_vwait, a_vval, vcnt;
   logic [VSW_W-1:0] a_vsw;
   logic             frame_end, frame_go, de_win;
   logic             run_w, sync_w, hs_hi_w, vs_hi_w;

   assign run_w    = ctrl_q.run;
   assign sync_w   = ctrl_q.sync_en;
   assign hs_hi_w  = ctrl_q.hs_hi;
   assign vs_hi_w  = ctrl_q.vs_hi;
   assign clk_fall = ctrl_q.fall;

   lcd_tg_regs #(
      .HW(HW), .VW(VW), .WW(WW), .VSW_W(VSW_W), .HSW_W(HSW_W),
      .HSW_LSB(HSW_LSB), .AW(AW), .DLY_W(DLY_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_end(frame_end), .frame_go(frame_go),
      .ctrl_q(ctrl_q), .dly_q(dly_code), .a_htot(a_htot), .a_hsw(a_hsw),
      .a_hwait(a_hwait), .a_hval(a_hval), .a_vtot(a_vtot), .a_vsw(a_vsw),
      .a_vwait(a_vwait), .a_vval(a_vval), .cur_base(cur_base)
   );

   lcd_tg_counter #(.HW(HW), .VW(VW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_w), .htot(a_htot), .vtot(a_vtot),
      .hcnt(hcnt), .vcnt(vcnt), .frame_end(frame_end), .frame_go(frame_go)
   );

   lcd_tg_outgen #(
      .HW(HW), .VW(VW), .WW(WW), .VSW_W(VSW_W), .HSW_W(HSW_W)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .hcnt(hcnt), .vcnt(vcnt),
      .hsw(a_hsw), .hwait(a_hwait), .hval(a_hval), .vsw(a_vsw),
      .vwait(a_vwait), .vval(a_vval), .hsync(hsync), .vsync(vsync),
      .de(de), .pix_req(pix_req), .line_start(line_start),
      .frame_start(frame_start), .de_win(de_win)
   );

endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          sync_en,
   input logic          hs_hi,
   input logic          vs_hi,
   input logic          hsync,
   input logic          vsync,
   input logic          pix_req,
   input logic          de_win,
   input logic          line_start,
   input logic          frame_start,
   input logic [AW-1:0] cur_base
);

   // R7: a frame start is always also a line start
   a_r7_frame_on_line: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> line_start);

   // R7 / R2: line starts are single-clock pulses (total of at least 2)
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> !line_start);

   // R9: no pulse while stopped
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) |-> !line_start);

   // R9: sync outputs inactive while sync enable is clear
   a_r9_hs_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sync_en) |-> (hsync == !$past(hs_hi)));
   a_r9_vs_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sync_en) |-> (vsync == !$past(vs_hi)));

   // R8: base address moves only with a frame start
   a_r8_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |-> $stable(cur_base));

   // R6: a pixel request is followed by an active pixel
   a_r6_req_leads: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && run) |=> de_win);

endmodule

bind lcd_timing_gen lcd_tg_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_w), .sync_en(sync_w),
   .hs_hi(hs_hi_w), .vs_hi(vs_hi_w), .hsync(hsync), .vsync(vsync),
   .pix_req(pix_req), .de_win(de_win), .line_start(line_start),
   .frame_start(frame_start), .cur_base(cur_base)
);

// File: tb/lcd_timing_gen_bench.sv
`timescale 1ns/1ps
module lcd_timing_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        hsync, vsync, de, pix_req, line_start, frame_start, clk_fall;
   logic [2:0]  dly_code;
   logic [31:0] cur_base;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lcd_timing_gen u_lcd_timing_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
      .pix_req(pix_req), .line_start(line_start), .frame_start(frame_start),
      .clk_fall(clk_fall), .dly_code(dly_code), .cur_base(cur_base)
   );

   // behavioural reference
   bit m_run, m_sync, m_den, m_vshi, m_hshi, m_dehi, m_fall;
   int m_dly;
   int s_htot, s_hsw, s_hwait, s_hval, s_vtot, s_vsw, s_vwait, s_vval;
   int a_htot, a_hsw, a_hwait, a_hval, a_vtot, a_vsw, a_vwait, a_vval;
   int h, v;
   longint nb, cb;
   bit e_hs = 1, e_vs = 1, e_de = 1, e_pr, e_ls, e_fs;

   task automatic load_active();
      a_htot = s_htot; a_hsw = s_hsw; a_hwait = s_hwait; a_hval = s_hval;
      a_vtot = s_vtot; a_vsw = s_vsw; a_vwait = s_vwait; a_vval = s_vval;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_run, m_sync, m_den, m_vshi, m_hshi, m_dehi, m_fall} = '0;
         m_dly = 0;
         s_htot = 0; s_hsw = 0; s_hwait = 0; s_hval = 0;
         s_vtot = 0; s_vsw = 0; s_vwait = 0; s_vval = 0;
         load_active();
         h = 0; v = 0; nb = 0; cb = 0;
         e_hs = 1; e_vs = 1; e_de = 1; e_pr = 0; e_ls = 0; e_fs = 0;
      end else begin
         bit vin, hs_on, vs_on, de_on, pr_on, last;
         hs_on = m_run && (h < a_hsw);
         vs_on = m_run && (v < a_vsw);
         vin   = (v >= a_vwait) && (v < a_vwait + a_vval);
         de_on = m_run && vin && (h >= a_hwait) && (h < a_hwait + a_hval);
         pr_on = m_run && vin && (h + 1 >= a_hwait) && (h + 1 < a_hwait + a_hval);
         e_hs = (m_sync && hs_on) ? m_hshi : !m_hshi;
         e_vs = (m_sync && vs_on) ? m_vshi : !m_vshi;
         e_de = (m_den && de_on) ? m_dehi : !m_dehi;
         e_pr = pr_on;
         e_ls = m_run && (h == 0);
         e_fs = e_ls && (v == 0);
         if (e_fs) cb = nb;
         if (!m_run) begin
            h = 0; v = 0;
            load_active();
         end else begin
            last = (h == a_htot - 1) && (v == a_vtot - 1);
            if (h == a_htot - 1) begin
               h = 0;
               v = (v == a_vtot - 1) ? 0 : v + 1;
            end else h = h + 1;
            if (last) load_active();
         end
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin
                  m_run = wr_data[0]; m_sync = wr_data[1]; m_den = wr_data[2];
                  m_vshi = wr_data[3]; m_hshi = wr_data[4]; m_dehi = wr_data[5];
                  m_fall = wr_data[6]; m_dly = int'(wr_data[10:8]);
               end
               3'd1: begin s_htot = int'(wr_data[17:0]); s_hsw = int'(wr_data[31:18]); end
               3'd2: s_vtot = int'(wr_data[15:0]);
               3'd3: begin s_hwait = int'(wr_data[27:16]); s_vwait = int'(wr_data[15:0]); end
               3'd4: s_vsw = int'(wr_data[17:0]);
               3'd5: begin s_vval = int'(wr_data[31:16]); s_hval = int'(wr_data[15:0]); end
               3'd6: nb = longint'(wr_data);
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 R9 R12 hsync", hsync, e_hs);
         chk("R4 R9 vsync", vsync, e_vs);
         chk("R5 de", de, e_de);
         chk("R6 pix_req", pix_req, e_pr);
         chk("R2 R7 R10 line_start", line_start, e_ls);
         chk("R2 R7 R10 frame_start", frame_start, e_fs);
         chk("R8 cur_base", cur_base, cb);
         chk("R11 clk_fall", clk_fall, m_fall);
         chk("R11 dly_code", dly_code, m_dly);
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset levels
      chk("R1 hsync", hsync, 1); chk("R1 vsync", vsync, 1);
      chk("R1 de", de, 1); chk("R1 pix_req", pix_req, 0);
      chk("R1 line_start", line_start, 0); chk("R1 cur_base", cur_base, 0);
      chk("R1 dly_code", dly_code, 0);
      rst_n = 1'b1;
      idle(2);
      // first mode: 12 clocks x 8 lines
      wr(1, (32'd2 << 18) | 32'd12);
      wr(2, 32'd8);
      wr(3, (32'd4 << 16) | 32'd3);
      wr(4, 32'd1);
      wr(5, (32'd3 << 16) | 32'd5);
      wr(6, 32'h0000_1000);
      wr(0, 32'h0000_053F);
      idle(250);
      // R8: pan while running
      wr(6, 32'h0000_2000);
      idle(120);
      // R10: new timing mid-frame, applies at next frame start
      wr(1, (32'd3 << 18) | 32'd10);
      wr(3, (32'd5 << 16) | 32'd2);
      wr(5, (32'd2 << 16) | 32'd4);
      wr(2, 32'd6);
      wr(4, 32'd2);
      idle(200);
      // R3 R4 R5 R11: active-low polarities, falling edge, new delay code
      wr(0, 32'h0000_0247);
      idle(150);
      // R9: sync outputs gated off
      wr(0, 32'h0000_0245);
      idle(100);
      // R5: data-enable output disabled
      wr(0, 32'h0000_0003);
      idle(80);
      // R9: stop, then restart
      wr(0, 32'h0000_0006);
      idle(40);
      wr(6, 32'h0000_3000);
      wr(0, 32'h0000_0737);
      idle(150);
      finish_run();
   end

endmodule